// File: doc/BRIEF.md
# Masked-Output GPIO Port

A general-purpose I/O port of up to sixteen pins that sits behind a simple memory-mapped register bus. Software selects one of four drive styles per pin, writes output levels either port-wide or one pin at a time, and reads the synchronised pad levels back. The pad side is a set of plain drive signals for each pin: an output value, an output enable and a weak pull-up enable. The pad's sensed level comes in on its own input.

A port-wide write to the output data register is filtered by a write mask, so bits whose mask bit is set keep their old value. Each pin also has a single-word data alias inside a pin-data window. Writing bit 0 of that word sets the pin's output bit regardless of the mask, and reading it returns the pin's level in bit 0. Each pin's digital input path can be turned off, and a pin that is turned off reads as 0 everywhere.

The bus is a plain request interface with no back-pressure: a request is taken in the cycle `bus_sel` is high. A read returns its data with `bus_rvalid` one cycle later. The port takes a new request every cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is in input mode (`pad_oe` and `pad_pu` all 0), and the mode, output data, output mask and input-disable registers read back 0.
- R2: The mode field of pin n is bits [2n+1:2n] of the mode register (byte offset 0x00), encoded 0 input, 1 push-pull, 2 open-drain, 3 quasi-bidirectional. In push-pull mode the pin drives its output bit with `pad_oe` = 1. In input mode `pad_oe` and `pad_pu` are 0.
- R3: In open-drain mode `pad_out` is 0 and `pad_oe` is the inverse of the pin's output bit, so the pin pulls low for 0 and releases for 1.
- R4: In quasi-bidirectional mode `pad_out` is 0, `pad_oe` is the inverse of the output bit, and `pad_pu` equals the output bit. `pad_pu` is 0 in every other mode.
- R5: A write to the output data register (offset 0x08) leaves unchanged every bit whose bit is set in the output mask register (offset 0x0C) and loads the others. Both registers read back.
- R6: A write to pin n's data word at byte address 0x800 + 0x40·PORT_IDX + 4·n loads bit 0 of the write data into output bit n, whatever the mask holds. Other output bits are unchanged.
- R7: A read of pin n's data word returns the pin's input level in bit 0 and 0 in bits [31:1].
- R8: The port input register (offset 0x10) returns every pin's pad level after SYNC_STAGES clock edges of synchronisation.
- R9: The input-disable register (offset 0x04) holds one bit per pin at bit n+16. A set bit makes that pin read as 0 in the input register and in its data word.
- R10: `bus_rvalid` is high exactly one cycle after each read request, and never after a write. Reads of unmapped addresses, including the data words of other ports, return 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request strobe, one request per cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | PIN_N | Pad sensed levels (asynchronous) |
| pad_out | output | PIN_N | Pad output value |
| pad_oe | output | PIN_N | Pad output enable |
| pad_pu | output | PIN_N | Pad weak pull-up enable |

## Verification
The bench loads output data through a mask of mixed bits, then writes single pins whose mask bits are set. A design that applied the mask to per-pin words, or ignored it on port writes, would leave the wrong value in the output register. Each of the four modes is applied to the same output pattern. A wrong open-drain or quasi-bidirectional decode would show up at once as a driven high or a misplaced pull-up. The input-disable bit is placed at n+16 and read through both the port register and the pin's own word, which catches an off-by-sixteen field or a disable that gates only one of the two paths. Reads to another port's window must return 0 and writes there must leave the output alone, which catches a window decode that ignores the port index.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    PM_INPUT = 2'd0,
    PM_PUSH  = 2'd1,
    PM_DRAIN = 2'd2,
    PM_QUASI = 2'd3
  } pin_mode_e;

  localparam int OFF_MODE   = 'h00;
  localparam int OFF_DINOFF = 'h04;
  localparam int OFF_DOUT   = 'h08;
  localparam int OFF_MASK   = 'h0C;
  localparam int OFF_PIN    = 'h10;
  localparam int ALIAS_BASE = 'h800;
  localparam int ALIAS_STEP = 'h40;
  localparam int DINOFF_LSB = 16;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PIN_N       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_N-1:0] pad_in,
  input  logic [PIN_N-1:0] dinoff,
  output logic [PIN_N-1:0] pin_lvl
);
  logic [SYNC_STAGES-1:0][PIN_N-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= pad_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  // a disabled input path reads as 0 at once
  assign pin_lvl = stage_q[SYNC_STAGES-1] & ~dinoff;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_mask_pkg::*;
#(
  parameter int PIN_N = 16
) (
  input  logic [PIN_N-1:0][1:0] mode,
  input  logic [PIN_N-1:0]      dout,
  output logic [PIN_N-1:0]      pad_out,
  output logic [PIN_N-1:0]      pad_oe,
  output logic [PIN_N-1:0]      pad_pu
);
  genvar i;
  generate
    for (i = 0; i < PIN_N; i++) begin : g_pin
      always_comb begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = 1'b0;
        pad_pu[i]  = 1'b0;
        case (pin_mode_e'(mode[i]))
          PM_PUSH: begin
            pad_out[i] = dout[i];
            pad_oe[i]  = 1'b1;
          end
          PM_DRAIN: pad_oe[i] = ~dout[i];
          PM_QUASI: begin
            pad_oe[i] = ~dout[i];
            pad_pu[i] = dout[i];
          end
          default: ;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mask_pkg::*;
#(
  parameter int PIN_N    = 16,
  parameter int ADDR_W   = 12,
  parameter int PORT_IDX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic [PIN_N-1:0]      pin_lvl,
  output logic [PIN_N-1:0][1:0] mode_q,
  output logic [PIN_N-1:0]      dout_q,
  output logic [PIN_N-1:0]      mask_q,
  output logic [PIN_N-1:0]      dinoff_q,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid
);
  localparam int IDX_W = (PIN_N > 1) ? $clog2(PIN_N) : 1;
  localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(ALIAS_BASE + ALIAS_STEP * PORT_IDX);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(4 * PIN_N);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_DINOFF = ADDR_W'(OFF_DINOFF);
  localparam logic [ADDR_W-1:0] A_DOUT   = ADDR_W'(OFF_DOUT);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_PIN    = ADDR_W'(OFF_PIN);

  logic              wr_en, rd_en, win_hit;
  logic [ADDR_W-1:0] win_off;
  logic [IDX_W-1:0]  win_idx;
  logic [31:0]       rd_mux;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign win_off = bus_addr - WIN_LO;
  assign win_hit = (bus_addr >= WIN_LO) && (win_off < WIN_SPAN) && (win_off[1:0] == 2'b00);
  assign win_idx = win_off[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      dout_q   <= '0;
      mask_q   <= '0;
      dinoff_q <= '0;
    end else if (wr_en) begin
      if (win_hit) begin
        dout_q[win_idx] <= bus_wdata[0];
      end else begin
        case (bus_addr)
          A_MODE:   mode_q   <= bus_wdata[2*PIN_N-1:0];
          A_DINOFF: dinoff_q <= bus_wdata[DINOFF_LSB +: PIN_N];
          A_DOUT:   dout_q   <= (dout_q & mask_q) | (bus_wdata[PIN_N-1:0] & ~mask_q);
          A_MASK:   mask_q   <= bus_wdata[PIN_N-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (win_hit) begin
      rd_mux[0] = pin_lvl[win_idx];
    end else begin
      case (bus_addr)
        A_MODE:   rd_mux[2*PIN_N-1:0]            = mode_q;
        A_DINOFF: rd_mux[DINOFF_LSB +: PIN_N]    = dinoff_q;
        A_DOUT:   rd_mux[PIN_N-1:0]              = dout_q;
        A_MASK:   rd_mux[PIN_N-1:0]              = mask_q;
        A_PIN:    rd_mux[PIN_N-1:0]              = pin_lvl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int PIN_N       = 16,
  parameter int ADDR_W      = 12,
  parameter int PORT_IDX    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [PIN_N-1:0]  pad_in,
  output logic [PIN_N-1:0]  pad_out,
  output logic [PIN_N-1:0]  pad_oe,
  output logic [PIN_N-1:0]  pad_pu
);
  logic [PIN_N-1:0][1:0] mode_q;
  logic [PIN_N-1:0]      dout_q;
  logic [PIN_N-1:0]      mask_q;
  logic [PIN_N-1:0]      dinoff_q;
  logic [PIN_N-1:0]      pin_lvl;

  gpio_in_sync #(.PIN_N(PIN_N), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .dinoff(dinoff_q), .pin_lvl(pin_lvl)
  );

  gpio_regs #(.PIN_N(PIN_N), .ADDR_W(ADDR_W), .PORT_IDX(PORT_IDX)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_lvl(pin_lvl), .mode_q(mode_q), .dout_q(dout_q),
    .mask_q(mask_q), .dinoff_q(dinoff_q), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  gpio_pad_drive #(.PIN_N(PIN_N)) u_drive (
    .mode(mode_q), .dout(dout_q), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
#(
  parameter int PIN_N  = 16,
  parameter int ADDR_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rvalid,
  input logic [2*PIN_N-1:0] mode_q,
  input logic [PIN_N-1:0]   dout_q,
  input logic [PIN_N-1:0]   mask_q,
  input logic [PIN_N-1:0]   dinoff_q,
  input logic [PIN_N-1:0]   pin_lvl,
  input logic [PIN_N-1:0]   pad_out,
  input logic [PIN_N-1:0]   pad_oe,
  input logic [PIN_N-1:0]   pad_pu
);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);

  logic [PIN_N-1:0] od_vec, qb_vec;
  logic             rst_d;

  genvar i;
  generate
    for (i = 0; i < PIN_N; i++) begin : g_m
      assign od_vec[i] = (mode_q[2*i +: 2] == 2'd2);
      assign qb_vec[i] = (mode_q[2*i +: 2] == 2'd3);
    end
  endgenerate

  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d) begin
      assert_reset_quiet_R1: assert (pad_oe == '0 && pad_pu == '0 && dout_q == '0 && mask_q == '0)
        else $error("R1 pads or registers not cleared by reset");
    end
  end

  assert_drain_drive_R3: assert property (@(posedge clk) disable iff (rst)
    ((od_vec & (pad_out | (pad_oe ^ ~dout_q))) == '0));

  assert_quasi_pull_R4: assert property (@(posedge clk) disable iff (rst)
    (((pad_pu & ~qb_vec) == '0) && ((qb_vec & (pad_pu ^ dout_q)) == '0)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == A_DOUT)
      |=> ((dout_q & $past(mask_q)) == ($past(dout_q) & $past(mask_q))));

  assert_input_off_R9: assert property (@(posedge clk) disable iff (rst)
    ((pin_lvl & dinoff_q) == '0));

  assert_read_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PIN_N(PIN_N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .mode_q(mode_q), .dout_q(dout_q), .mask_q(mask_q),
  .dinoff_q(dinoff_q), .pin_lvl(pin_lvl), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  localparam int PIN_N = 16;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] WIN = 12'h880;  // port index 2

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [PIN_N-1:0]  pad_in = '0;
  logic [PIN_N-1:0]  pad_out, pad_oe, pad_pu;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_mask_port #(.PIN_N(PIN_N), .ADDR_W(ADDR_W), .PORT_IDX(2), .SYNC_STAGES(2)) u_gpio_mask_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: push the expected item, then issue the read
  task automatic bus_read(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pads(string tag, logic [15:0] o, logic [15:0] oe, logic [15:0] pu);
    check({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, o});
    check({tag, " pad_oe"},  {16'h0, pad_oe},  {16'h0, oe});
    check({tag, " pad_pu"},  {16'h0, pad_pu},  {16'h0, pu});
  endtask

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R10 rvalid with no read pending actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pads("R1 reset", 16'h0, 16'h0, 16'h0);
    bus_read(12'h000, 32'h0, "R1 mode reset");
    bus_read(12'h008, 32'h0, "R1 dout reset");
    bus_read(12'h00C, 32'h0, "R1 mask reset");
    bus_read(12'h004, 32'h0, "R1 dinoff reset");
    // R2 push-pull
    bus_write(12'h000, 32'h5555_5555);
    bus_write(12'h008, 32'h0000_A5C3);
    pads("R2 push-pull", 16'hA5C3, 16'hFFFF, 16'h0);
    bus_read(12'h000, 32'h5555_5555, "R2 mode readback");
    // R3 open-drain
    bus_write(12'h000, 32'hAAAA_AAAA);
    pads("R3 open-drain", 16'h0, 16'h5A3C, 16'h0);
    // R4 quasi
    bus_write(12'h000, 32'hFFFF_FFFF);
    pads("R4 quasi", 16'h0, 16'h5A3C, 16'hA5C3);
    // R2 input mode on pins 0..7, quasi above
    bus_write(12'h000, 32'hFFFF_0000);
    pads("R2 input low byte", 16'h0, 16'h5A00, 16'hA500);
    // R8 input sampling
    pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    bus_read(12'h010, 32'h0000_1234, "R8 pin input");
    pad_in = 16'hC00F;
    repeat (3) @(negedge clk);
    bus_read(12'h010, 32'h0000_C00F, "R8 pin input second");
    pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    // R5 masked port writes
    bus_write(12'h00C, 32'h0000_FF00);
    bus_write(12'h008, 32'h0000_1234);
    bus_read(12'h008, 32'h0000_A534, "R5 mask high byte");
    bus_write(12'h00C, 32'h0000_0F0F);
    bus_write(12'h008, 32'h0000_FFFF);
    bus_read(12'h008, 32'h0000_F5F4, "R5 mask nibbles");
    bus_read(12'h00C, 32'h0000_0F0F, "R5 mask readback");
    // R6 per-pin writes ignore the mask
    bus_write(WIN + 12'd8, 32'h0000_0000);   // pin 2, masked
    bus_read(12'h008, 32'h0000_F5F0, "R6 pin2 clear");
    bus_write(WIN + 12'd36, 32'h0000_0003);  // pin 9, bit 1 ignored
    bus_read(12'h008, 32'h0000_F7F0, "R6 pin9 set");
    // R7 per-pin reads
    bus_read(WIN + 12'd16, 32'h1, "R7 pin4 high");
    bus_read(WIN + 12'd0,  32'h0, "R7 pin0 low");
    bus_read(WIN + 12'd48, 32'h1, "R7 pin12 high");
    // R9 input disable for pin 4 at bit 20
    bus_write(12'h004, 32'h0010_0000);
    bus_read(12'h004, 32'h0010_0000, "R9 dinoff readback");
    bus_read(12'h010, 32'h0000_1224, "R9 pin input masked");
    bus_read(WIN + 12'd16, 32'h0, "R9 pin4 word masked");
    bus_write(12'h004, 32'h0000_0000);
    bus_read(WIN + 12'd16, 32'h1, "R9 pin4 restored");
    // R10 unmapped and other window
    bus_read(12'h7F0, 32'h0, "R10 unmapped read");
    bus_read(12'h840, 32'h0, "R10 other port read");
    bus_write(12'h840, 32'h0000_0001);  // pin 0 of port 1
    bus_write(12'h7F0, 32'hFFFF_FFFF);
    bus_read(12'h008, 32'h0000_F7F0, "R10 stray write no effect");
    repeat (3) @(negedge clk);
    check("R10 reads all answered", exp_q.size(), 0);
    finish_run();
  end
endmodule